// File: doc/BRIEF.md
# Three-Phase Integer Pipeline with Delayed Branch

This block is a small in-order integer core for a fixed 16-bit instruction format. Each instruction passes through up to three phases. In fetch, the program counter addresses an external synchronous instruction memory. In execute, the hardwired decoder reads two operands, the ALU produces a result or an effective address, and stores drive the data port. In the memory phase, load data returns and every result is written to an 8-entry register file. Register-to-register work finishes its useful computation in execute. Only loads and stores use the data port.

The core issues one instruction per cycle. A result still in flight is bypassed to the next instruction. The one exception is a value that a load has not yet returned: an instruction that needs it waits one cycle. Control transfers use delayed-branch semantics. The instruction after a branch or jump always executes, and fetch moves to the target only after it. Both memories are external and respond one cycle after the address.

Top module: `pipe3_core`

## Requirements
- R1: While reset is held and in the first cycle after release, the instruction address is 0 and the store strobe is low.
- R2: Opcodes 0 to 3 (add, subtract, AND, OR) write reg[[11:9]] with reg[[8:6]] combined with reg[[5:3]], modulo 2^16.
- R3: Opcode 4 writes reg[[11:9]] with reg[[8:6]] plus the sign-extended 6-bit field [5:0].
- R4: Opcode 5 loads reg[[11:9]] from data word reg[[8:6]] + sext([5:0]). Opcode 6 stores reg[[11:9]] to that same address, with the store strobe asserted in the execute cycle.
- R5: Register 0 reads as zero, and writes to it have no effect.
- R6: A result is bypassed to the next instruction with no lost cycle. A store follows the instruction before it by two fetch cycles.
- R7: An instruction that uses a load's destination right after the load waits exactly one cycle. The store in such a sequence comes three cycles after the second fetch.
- R8: Opcode 7 compares reg[[11:9]] with reg[[8:6]]. When they are equal, fetch continues at the branch address plus sext([5:0]), after the next instruction has executed.
- R9: When opcode 7 finds the registers unequal, execution continues in sequence.
- R10: Opcode 8 jumps to the absolute address in [7:0]. The instruction after it still executes.
- R11: Opcodes 9 to 15 change no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | PC_W | Instruction word address |
| imem_rdata | input | 16 | Instruction word, valid one cycle after its address |
| dmem_addr | output | DA_W | Data word address for loads and stores |
| dmem_we | output | 1 | Store strobe |
| dmem_wdata | output | DATA_W | Store data |
| dmem_rdata | input | DATA_W | Load data, valid one cycle after its address |

## Verification
The hardest case to reach is a load followed at once by an instruction that needs its result. The refetch this causes can only be seen as a one-cycle shift of later activity at the ports. The stimulus makes every arithmetic sweep program load both operands back to back, so each run passes through the stall. Separate short programs time the store strobe against the fetch of address 1, once with a load in front and once without.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int ILEN = 16;
  localparam int RIDX = 3;
  localparam int NREG = 8;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_ADDI = 4'd4;
  localparam logic [3:0] OP_LD   = 4'd5;
  localparam logic [3:0] OP_ST   = 4'd6;
  localparam logic [3:0] OP_BEQ  = 4'd7;
  localparam logic [3:0] OP_JMP  = 4'd8;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_OR} alu_fn_e;

  typedef struct packed {
    logic    wr;     // writes a register
    logic    use_a;  // reads [8:6]
    logic    use_b;  // reads a second register
    logic    b_hi;   // second register taken from [11:9]
    logic    imm;    // ALU B input is the immediate
    logic    ld;
    logic    st;
    logic    beq;
    logic    jmp;
    alu_fn_e fn;
  } ctl_t;

  function automatic ctl_t decode(input logic [3:0] op);
    ctl_t c;
    c = '{wr: 1'b0, use_a: 1'b0, use_b: 1'b0, b_hi: 1'b0, imm: 1'b0,
          ld: 1'b0, st: 1'b0, beq: 1'b0, jmp: 1'b0, fn: FN_ADD};
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR: begin
        c.wr = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1;
        c.fn = alu_fn_e'(op[1:0]);
      end
      OP_ADDI: begin c.wr = 1'b1; c.use_a = 1'b1; c.imm = 1'b1; end
      OP_LD:   begin c.wr = 1'b1; c.use_a = 1'b1; c.imm = 1'b1; c.ld = 1'b1; end
      OP_ST:   begin c.use_a = 1'b1; c.use_b = 1'b1; c.b_hi = 1'b1; c.imm = 1'b1; c.st = 1'b1; end
      OP_BEQ:  begin c.use_a = 1'b1; c.use_b = 1'b1; c.b_hi = 1'b1; c.beq = 1'b1; end
      OP_JMP:  c.jmp = 1'b1;
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pipe3_regfile.sv
module pipe3_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra,
  input  logic [AW-1:0]     rb,
  output logic [DATA_W-1:0] da,
  output logic [DATA_W-1:0] db
);
  logic [DATA_W-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) cells[wa] <= wd;
  end

  always_comb begin
    da = (ra == '0) ? '0 : cells[ra];
    db = (rb == '0) ? '0 : cells[rb];
  end
endmodule

// File: rtl/pipe3_alu.sv
module pipe3_alu
  import pipe3_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (fn)
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe3_operands.sv
module pipe3_operands #(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              e_valid,
  input  logic              use_a,
  input  logic              use_b,
  input  logic [AW-1:0]     src_a,
  input  logic [AW-1:0]     src_b,
  input  logic              m_wb,
  input  logic              m_ld,
  input  logic [AW-1:0]     m_rd,
  input  logic [DATA_W-1:0] m_val,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  output logic [DATA_W-1:0] opa,
  output logic [DATA_W-1:0] opb,
  output logic              stall
);
  logic hit_a, hit_b;

  always_comb begin
    hit_a = m_wb && (m_rd != '0) && (m_rd == src_a);
    hit_b = m_wb && (m_rd != '0) && (m_rd == src_b);
    stall = e_valid && m_ld && ((use_a && hit_a) || (use_b && hit_b));
    opa   = (hit_a && !m_ld) ? m_val : rf_a;
    opb   = (hit_b && !m_ld) ? m_val : rf_b;
  end

  // R5
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (e_valid && src_a == '0) |-> (opa == '0));
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 8,
  parameter int DA_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [ILEN-1:0]   imem_rdata,
  output logic [DA_W-1:0]   dmem_addr,
  output logic              dmem_we,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata
);
  localparam int IMM_W = 6;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // fetch / execute state
  logic [PC_W-1:0] pc_f, pc_f_n, pc_e, pc_e_n;
  logic            e_valid;
  // memory-phase state
  logic              m_wb, m_wb_n, m_ld, m_ld_n;
  logic [RIDX-1:0]   m_rd, m_rd_n;
  logic [DATA_W-1:0] m_val, m_val_n;

  ctl_t              ctl;
  logic [RIDX-1:0]   f_rd, f_rs, f_rt, src_b;
  logic [IMM_W-1:0]  f_imm;
  logic [DATA_W-1:0] imm_x, rf_a, rf_b, opa, opb, alu_b, alu_y, wb_data;
  logic [PC_W-1:0]   imm_pc, target;
  logic              stall, fire, taken;

  always_comb begin
    ctl    = decode(imem_rdata[15:12]);
    f_rd   = imem_rdata[11:9];
    f_rs   = imem_rdata[8:6];
    f_rt   = imem_rdata[5:3];
    f_imm  = imem_rdata[5:0];
    src_b  = ctl.b_hi ? f_rd : f_rt;
    imm_x  = {{(DATA_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    imm_pc = {{(PC_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  end

  pipe3_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .we(m_wb), .wa(m_rd), .wd(wb_data),
    .ra(f_rs), .rb(src_b), .da(rf_a), .db(rf_b));

  pipe3_operands #(.DATA_W(DATA_W), .AW(RIDX)) u_opnd (
    .clk(clk), .rst_i(rst_i), .e_valid(e_valid),
    .use_a(ctl.use_a), .use_b(ctl.use_b), .src_a(f_rs), .src_b(src_b),
    .m_wb(m_wb), .m_ld(m_ld), .m_rd(m_rd), .m_val(m_val),
    .rf_a(rf_a), .rf_b(rf_b), .opa(opa), .opb(opb), .stall(stall));

  assign alu_b = ctl.imm ? imm_x : opb;

  pipe3_alu #(.DATA_W(DATA_W)) u_alu (.fn(ctl.fn), .a(opa), .b(alu_b), .y(alu_y));

  // execute-phase control and next state
  always_comb begin
    fire   = e_valid && !stall;
    taken  = fire && (ctl.jmp || (ctl.beq && (opa == opb)));
    target = ctl.jmp ? imem_rdata[PC_W-1:0] : pc_e + imm_pc;
    imem_addr = stall ? pc_e : pc_f;
    pc_e_n = imem_addr;
    if (stall)      pc_f_n = pc_f;
    else if (taken) pc_f_n = target;
    else            pc_f_n = pc_f + 1'b1;
    m_wb_n  = fire && ctl.wr && (f_rd != '0);
    m_ld_n  = ctl.ld;
    m_rd_n  = f_rd;
    m_val_n = alu_y;
    dmem_addr  = alu_y[DA_W-1:0];
    dmem_wdata = opb;
    dmem_we    = fire && ctl.st;
    wb_data    = m_ld ? dmem_rdata : m_val;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pc_f    <= '0;
      pc_e    <= '0;
      e_valid <= 1'b0;
      m_wb    <= 1'b0;
      m_ld    <= 1'b0;
      m_rd    <= '0;
    end else begin
      pc_f    <= pc_f_n;
      pc_e    <= pc_e_n;
      e_valid <= 1'b1;
      m_wb    <= m_wb_n;
      m_ld    <= m_ld_n;
      m_rd    <= m_rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) m_val <= m_val_n;
  end

  // R7
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_i)
    stall |=> !stall);
  // R7
  stall_refetch_chk: assert property (@(posedge clk) disable iff (!rst_i)
    stall |=> (pc_e == $past(pc_e)));
  // R8
  slot_runs_chk: assert property (@(posedge clk) disable iff (!rst_i)
    taken |=> (pc_e == PC_W'($past(pc_e) + 1'b1)));
  // R10
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_i)
    taken |=> (stall || imem_addr == $past(target)));
  // R4
  store_bubble_chk: assert property (@(posedge clk) disable iff (!rst_i)
    stall |-> !dmem_we);
endmodule

// File: tb/pipe3_core_test.sv
module pipe3_core_test;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic [5:0]  dmem_addr;
  logic        dmem_we;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata;

  logic [15:0] imem [256];
  logic [15:0] dmem [64];

  int checks = 0, errors = 0;
  int first1, firstwe;
  logic [7:0] addr0;
  logic       we0;

  always #(CLK_T/2) clk = ~clk;

  pipe3_core uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata));

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr];
    dmem_rdata <= dmem[dmem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input int a, input int b, input int c);
    return {op, 3'(a), 3'(b), 6'(c)};
  endfunction
  function automatic logic [15:0] rr(input logic [3:0] op, input int d, input int s, input int t);
    return ins(op, d, s, t * 8);
  endfunction
  function automatic logic [15:0] val(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      default: return 16'(i * 20011 + 7);
    endcase
  endfunction
  function automatic logic [15:0] ref_alu(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 64; i++) dmem[i] = 16'h0000;
  endtask

  task automatic run(input int n);
    first1 = -1; firstwe = -1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (c == 0) begin addr0 = imem_addr; we0 = dmem_we; end
      if (imem_addr == 8'd1 && first1 < 0) first1 = c;
      if (dmem_we && firstwe < 0) firstwe = c;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    // R1 reset state
    clear();
    @(negedge clk);
    check(imem_addr == 8'd0 && dmem_we == 1'b0, "R1 in reset", imem_addr, 0);

    // R6 forwarding chain and timing
    clear();
    imem[0] = ins(4'd4, 1, 0, 5);
    imem[1] = rr(4'd0, 2, 1, 1);
    imem[2] = ins(4'd6, 2, 0, 2);
    imem[3] = ins(4'd8, 0, 0, 3);
    run(14);
    check(addr0 == 8'd0 && we0 == 1'b0, "R1 after release", addr0, 0);
    check(dmem[2] == 16'd10, "R6 bypass value", dmem[2], 10);
    check(firstwe - first1 == 2, "R6 no lost cycle", firstwe - first1, 2);

    // R7 load-use stall timing
    clear();
    dmem[0] = 16'd21;
    imem[0] = ins(4'd5, 1, 0, 0);
    imem[1] = rr(4'd0, 2, 1, 1);
    imem[2] = ins(4'd6, 2, 0, 2);
    imem[3] = ins(4'd8, 0, 0, 3);
    run(14);
    check(dmem[2] == 16'd42, "R7 load-use value", dmem[2], 42);
    check(firstwe - first1 == 3, "R7 one-cycle stall", firstwe - first1, 3);

    // R2 sweep: 4 ops x 8 x 8 operand pairs, loads back to back
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          clear();
          dmem[0] = val(i); dmem[1] = val(j);
          imem[0] = ins(4'd5, 1, 0, 0);
          imem[1] = ins(4'd5, 2, 0, 1);
          imem[2] = rr(4'(op), 3, 1, 2);
          imem[3] = ins(4'd6, 3, 0, 2);
          imem[4] = ins(4'd8, 0, 0, 4);
          run(14);
          check(dmem[2] == ref_alu(op, val(i), val(j)), "R2 alu op", dmem[2],
                ref_alu(op, val(i), val(j)));
        end

    // R3 sweep: every immediate, two bases
    for (int b = 2; b < 4; b++)
      for (int k = 0; k < 64; k++) begin
        clear();
        dmem[0] = val(b);
        imem[0] = ins(4'd5, 1, 0, 0);
        imem[1] = ins(4'd4, 2, 1, k);
        imem[2] = ins(4'd6, 2, 0, 2);
        imem[3] = ins(4'd8, 0, 0, 3);
        run(14);
        check(dmem[2] == 16'(val(b) + ((k >= 32) ? k - 64 : k)), "R3 addi", dmem[2],
              16'(val(b) + ((k >= 32) ? k - 64 : k)));
      end

    // R4 negative and positive offsets
    clear();
    dmem[7] = 16'hBEEF;
    imem[0] = ins(4'd4, 1, 0, 10);
    imem[1] = ins(4'd5, 2, 1, -3);
    imem[2] = ins(4'd6, 2, 1, 20);
    imem[3] = ins(4'd8, 0, 0, 3);
    run(14);
    check(dmem[30] == 16'hBEEF, "R4 load/store offsets", dmem[30], 16'hBEEF);

    // R5 register zero
    clear();
    imem[0] = ins(4'd4, 0, 0, 5);
    imem[1] = rr(4'd0, 1, 0, 0);
    imem[2] = ins(4'd6, 0, 0, 6);
    imem[3] = ins(4'd6, 1, 0, 7);
    imem[4] = ins(4'd8, 0, 0, 4);
    dmem[6] = 16'h1111; dmem[7] = 16'h2222;
    run(14);
    check(dmem[6] == 16'h0000, "R5 r0 store", dmem[6], 0);
    check(dmem[7] == 16'h0000, "R5 r0 operand", dmem[7], 0);

    // R8 taken branch with delay slot, R9 not taken
    for (int nt = 0; nt < 2; nt++) begin
      clear();
      imem[0] = ins(4'd4, 4, 0, 1);
      imem[1] = ins(4'd4, 1, 0, 5);
      imem[2] = ins(4'd4, 2, 0, 5 + nt);
      imem[3] = ins(4'd7, 1, 2, 4);
      imem[4] = ins(4'd4, 3, 0, 7);
      imem[5] = ins(4'd4, 4, 0, 9);
      imem[6] = ins(4'd4, 5, 0, 2);
      imem[7] = ins(4'd6, 3, 0, 3);
      imem[8] = ins(4'd6, 4, 0, 4);
      imem[9] = ins(4'd8, 0, 0, 9);
      run(20);
      check(dmem[3] == 16'd7, nt ? "R9 slot/sequence" : "R8 delay slot", dmem[3], 7);
      check(dmem[4] == (nt ? 16'd9 : 16'd1), nt ? "R9 fall through" : "R8 skipped",
            dmem[4], nt ? 9 : 1);
    end

    // R10 jump with delay slot
    clear();
    imem[0] = ins(4'd4, 4, 0, 1);
    imem[1] = {4'd8, 4'd0, 8'd5};
    imem[2] = ins(4'd4, 3, 0, 7);
    imem[3] = ins(4'd4, 4, 0, 9);
    imem[4] = ins(4'd4, 4, 0, 9);
    imem[5] = ins(4'd6, 3, 0, 3);
    imem[6] = ins(4'd6, 4, 0, 4);
    imem[7] = ins(4'd8, 0, 0, 7);
    run(18);
    check(dmem[3] == 16'd7, "R10 delay slot", dmem[3], 7);
    check(dmem[4] == 16'd1, "R10 skipped", dmem[4], 1);

    // R11 unused opcodes
    for (int op = 9; op < 16; op++) begin
      clear();
      dmem[0] = 16'h0055;
      imem[0] = ins(4'd4, 1, 0, 3);
      imem[1] = rr(4'(op), 1, 1, 1);
      imem[2] = ins(4'd6, 1, 0, 7);
      imem[3] = ins(4'd8, 0, 0, 3);
      run(14);
      check(dmem[7] == 16'd3 && dmem[0] == 16'h0055 && dmem[1] == 16'h0000,
            "R11 no effect", dmem[7], 3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule